// File: doc/BRIEF.md
# Reconfigurable Output Macrocell

This block is one output cell of a small programmable logic device. It receives a set of product terms from the device's AND array, forms their sum, applies a selectable polarity and then, as three configuration bits decide, drives its pad straight from that logic, drives it from a D flip-flop, or leaves the pad undriven so that the pin acts as an input. It also returns one feedback signal to the array. Depending on the mode, that signal is the cell's own pad, the register state, the neighbouring cell's pad, or a constant zero.

The configuration bits are a device-wide sequential-select bit (`seq_n`), an architecture bit shared by all cells (`arch_shared`) and an architecture bit that belongs to this cell (`arch_cell`). Together they form a code `{seq_n, arch_shared, arch_cell}`. Five codes are legal. Code 101 makes the pin a dedicated input. Code 100 gives a combinational output that is always enabled. Code 111 gives a combinational output whose enable comes from a product term, with feedback. Code 010 gives a registered output. Code 011 gives a combinational output inside a registered device. The pad driver inverts, so with `invert` at 0 the pin function is active low.

Top module: `pld_out_cell`

## Requirements
- R1: Codes 100 and 010 use all eight terms: the sum is the OR of `terms[7:0]`.
- R2: The polarity stage passes the sum unchanged when `invert`=0 and complements it when `invert`=1.
- R3: In the combinational codes (100, 111, 011), `pad_out` is the complement of the polarity-stage result.
- R4: Code 101 (dedicated input) holds `pad_oe` at 0.
- R5: Code 100 holds `pad_oe` at 1. In codes 100 and 101, `fb_out` equals `nbr_pad_in` when `nbr_arch_cell`=1, and 0 when `nbr_arch_cell`=0.
- R6: In codes 111 and 011, `pad_oe` equals `terms[0]`, the sum covers only `terms[7:1]`, and `fb_out` equals `pad_in`.
- R7: The flip-flop samples the polarity result of all eight terms on each rising `clk` edge. In code 010, `pad_out` is the complement of the stored bit, `pad_oe` equals `oe_shared`, and `fb_out` equals the stored bit.
- R8: Code 011 drives `pad_out` combinationally from the current terms, and not from the flip-flop.
- R9: A rising edge with `rst`=1 clears the stored bit to 0, so in code 010 `pad_out` reads 1 and `fb_out` reads 0.
- R10: Codes 000, 001 and 110 hold `pad_oe` and `fb_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common device clock for the flip-flop |
| rst | input | 1 | Synchronous active-high test reset of the flip-flop |
| terms | input | 8 | Product terms from the AND array; bit 0 is the first term |
| seq_n | input | 1 | Device-wide select bit (0 = registered device) |
| arch_shared | input | 1 | Architecture bit shared by all cells |
| arch_cell | input | 1 | Architecture bit of this cell |
| invert | input | 1 | Polarity select |
| oe_shared | input | 1 | Shared external output enable for registered mode |
| pad_in | input | 1 | Value seen on this cell's pad |
| nbr_pad_in | input | 1 | Value seen on the neighbouring cell's pad |
| nbr_arch_cell | input | 1 | Per-cell architecture bit of the neighbour |
| pad_out | output | 1 | Data to the pad driver |
| pad_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback to the AND array |

## Verification
The hardest case to reach from the ports is the registered path. In code 010 the pad shows a value captured one edge earlier, and a reset edge must win over terms that would otherwise load a 1. The bench sweeps every code against every term pattern, both polarities and all side inputs. It models the stored bit from the inputs it applied before each edge, so registered and combinational views are checked on the same vectors. It then forces a reset edge while the terms are active and checks the cleared state at the pads.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

  typedef enum logic [2:0] {
    M_INVALID  = 3'd0,
    M_DEDIN    = 3'd1,
    M_COMB     = 3'd2,
    M_COMBFB   = 3'd3,
    M_REG      = 3'd4,
    M_REGCOMB  = 3'd5
  } cell_mode_e;

  // Code order is {seq_n, arch_shared, arch_cell}
  function automatic cell_mode_e decode_mode(input logic s, input logic a0, input logic a1);
    case ({s, a0, a1})
      3'b101:  return M_DEDIN;
      3'b100:  return M_COMB;
      3'b111:  return M_COMBFB;
      3'b010:  return M_REG;
      3'b011:  return M_REGCOMB;
      default: return M_INVALID;
    endcase
  endfunction

endpackage

// File: rtl/pld_mode_decode.sv
module pld_mode_decode
  import pld_cell_pkg::*;
(
  input  logic       seq_n,
  input  logic       arch_shared,
  input  logic       arch_cell,
  output cell_mode_e mode,
  output logic       pt_enable,
  output logic       nbr_route
);

  always_comb begin
    mode      = decode_mode(seq_n, arch_shared, arch_cell);
    pt_enable = (mode == M_COMBFB) || (mode == M_REGCOMB);
    nbr_route = (mode == M_DEDIN) || (mode == M_COMB);
  end

  always_comb begin
    if (mode == M_INVALID) begin
      assert ({seq_n, arch_shared, arch_cell} inside {3'b000, 3'b001, 3'b110})
        else $error("p_invalid_codes_r10: legal code decoded as invalid");
    end
  end

endmodule

// File: rtl/pld_sum_stage.sv
module pld_sum_stage #(
  parameter int N_TERMS = 8
) (
  input  logic [N_TERMS-1:0] terms,
  input  logic               drop_first,
  input  logic               invert,
  output logic               full_x,
  output logic               sel_x
);

  localparam int LAST = N_TERMS - 1;

  logic [N_TERMS-1:0] mask;

  generate
    for (genvar i = 0; i < N_TERMS; i++) begin : g_mask
      if (i == 0) begin : g_first
        assign mask[i] = ~drop_first;
      end else begin : g_rest
        assign mask[i] = 1'b1;
      end
    end
  endgenerate

  logic full_or, sel_or;

  always_comb begin
    full_or = |terms;
    sel_or  = |(terms & mask);
    full_x  = full_or ^ invert;
    sel_x   = sel_or ^ invert;
  end

  always_comb begin
    if (drop_first && terms[0] && (terms[LAST:1] == '0)) begin
      assert (sel_x == invert)
        else $error("p_first_excluded_r6: enable term leaked into the sum");
    end
  end

endmodule

// File: rtl/pld_out_reg.sv
module pld_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q == $past(d)))
    else $error("p_capture_r7");

  p_clear_r9: assert property (@(posedge clk)
    rst |=> (q == 1'b0))
    else $error("p_clear_r9");

endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int N_TERMS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_TERMS-1:0] terms,
  input  logic               seq_n,
  input  logic               arch_shared,
  input  logic               arch_cell,
  input  logic               invert,
  input  logic               oe_shared,
  input  logic               pad_in,
  input  logic               nbr_pad_in,
  input  logic               nbr_arch_cell,
  output logic               pad_out,
  output logic               pad_oe,
  output logic               fb_out
);

  cell_mode_e mode;
  logic       pt_enable, nbr_route;
  logic       full_x, sel_x, q_state;

  pld_mode_decode u_dec (
    .seq_n       (seq_n),
    .arch_shared (arch_shared),
    .arch_cell   (arch_cell),
    .mode        (mode),
    .pt_enable   (pt_enable),
    .nbr_route   (nbr_route)
  );

  pld_sum_stage #(.N_TERMS(N_TERMS)) u_sum (
    .terms      (terms),
    .drop_first (pt_enable),
    .invert     (invert),
    .full_x     (full_x),
    .sel_x      (sel_x)
  );

  pld_out_reg u_reg (
    .clk (clk),
    .rst (rst),
    .d   (full_x),
    .q   (q_state)
  );

  always_comb begin
    pad_out = ~sel_x;
    pad_oe  = 1'b0;
    fb_out  = 1'b0;
    case (mode)
      M_DEDIN: begin
        fb_out = nbr_route & nbr_arch_cell & nbr_pad_in;
      end
      M_COMB: begin
        pad_oe = 1'b1;
        fb_out = nbr_route & nbr_arch_cell & nbr_pad_in;
      end
      M_COMBFB, M_REGCOMB: begin
        pad_oe = terms[0];
        fb_out = pad_in;
      end
      M_REG: begin
        pad_out = ~q_state;
        pad_oe  = oe_shared;
        fb_out  = q_state;
      end
      default: begin
        pad_oe = 1'b0;
        fb_out = 1'b0;
      end
    endcase
  end

  p_dedin_off_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == M_DEDIN) |-> !pad_oe)
    else $error("p_dedin_off_r4");

  p_comb_on_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == M_COMB) |-> pad_oe)
    else $error("p_comb_on_r5");

  p_pt_enable_r6: assert property (@(posedge clk) disable iff (rst)
    pt_enable |-> (pad_oe == terms[0] && fb_out == pad_in))
    else $error("p_pt_enable_r6");

  p_reg_view_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == M_REG) |-> (fb_out == q_state && pad_out != q_state))
    else $error("p_reg_view_r7");

  p_invalid_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (mode == M_INVALID) |-> (!pad_oe && !fb_out))
    else $error("p_invalid_quiet_r10");

endmodule

// File: tb/pld_out_cell_tb_top.sv
`timescale 1ns/1ps
module pld_out_cell_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] terms;
  logic       seq_n, arch_shared, arch_cell, invert;
  logic       oe_shared, pad_in, nbr_pad_in, nbr_arch_cell;
  logic       pad_out, pad_oe, fb_out;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;
  logic q_exp;

  always #4 clk = ~clk;

  pld_out_cell #(.N_TERMS(8)) dut_i (
    .clk(clk), .rst(rst), .terms(terms), .seq_n(seq_n),
    .arch_shared(arch_shared), .arch_cell(arch_cell), .invert(invert),
    .oe_shared(oe_shared), .pad_in(pad_in), .nbr_pad_in(nbr_pad_in),
    .nbr_arch_cell(nbr_arch_cell), .pad_out(pad_out), .pad_oe(pad_oe),
    .fb_out(fb_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s code=%b terms=%h inv=%b actual=%b expected=%b",
               req, {seq_n, arch_shared, arch_cell}, terms, invert, act, exp);
    end
  endtask

  // Bench model of the flip-flop: updated at each rising edge from applied inputs
  always @(posedge clk) begin
    if (rst) q_exp <= 1'b0;
    else     q_exp <= (|terms) ^ invert;
  end

  task automatic check_outputs();
    logic [2:0] code;
    logic s7, s8;
    code = {seq_n, arch_shared, arch_cell};
    s8 = (|terms) ^ invert;          // R1 R2
    s7 = (|terms[7:1]) ^ invert;     // R6 sum
    case (code)
      3'b101: begin
        check("R4", pad_oe, 1'b0);
        check("R5", fb_out, nbr_arch_cell & nbr_pad_in);
      end
      3'b100: begin
        check("R5", pad_oe, 1'b1);
        check("R1/R3", pad_out, ~s8);
        check("R5", fb_out, nbr_arch_cell & nbr_pad_in);
      end
      3'b111: begin
        check("R6", pad_oe, terms[0]);
        check("R6/R3", pad_out, ~s7);
        check("R6", fb_out, pad_in);
      end
      3'b011: begin
        check("R6", pad_oe, terms[0]);
        check("R8", pad_out, ~s7);
        check("R6", fb_out, pad_in);
      end
      3'b010: begin
        check("R7", pad_oe, oe_shared);
        check("R7", pad_out, ~q_exp);
        check("R7", fb_out, q_exp);
      end
      default: begin
        check("R10", pad_oe, 1'b0);
        check("R10", fb_out, 1'b0);
      end
    endcase
  endtask

  initial begin
    rst = 1'b1; terms = '0; {seq_n, arch_shared, arch_cell} = 3'b010;
    invert = 1'b0; oe_shared = 1'b1; pad_in = 1'b0;
    nbr_pad_in = 1'b0; nbr_arch_cell = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    terms = 8'hFF;
    #1;
    // R9: reset state seen through registered mode
    check("R9", pad_out, 1'b1);
    check("R9", fb_out, 1'b0);
    rst = 1'b0;

    for (int code = 0; code < 8; code++) begin
      for (int t = 0; t < 256; t++) begin
        for (int inv = 0; inv < 2; inv++) begin
          for (int side = 0; side < 16; side++) begin
            @(negedge clk);
            {seq_n, arch_shared, arch_cell} = 3'(code);
            terms = 8'(t);
            invert = inv[0];
            {oe_shared, pad_in, nbr_pad_in, nbr_arch_cell} = 4'(side);
            #1;
            check_outputs();
          end
        end
      end
    end

    // R9: reset edge overrides terms that would load a 1
    @(negedge clk);
    {seq_n, arch_shared, arch_cell} = 3'b010;
    terms = 8'h81; invert = 1'b0; oe_shared = 1'b1;
    @(negedge clk);
    #1;
    check("R7", fb_out, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; terms = 8'h00; invert = 1'b0;
    #1;
    check("R9", fb_out, 1'b0);
    check("R9", pad_out, 1'b1);
    // R2: inverted polarity with no terms loads a 1
    invert = 1'b1;
    @(negedge clk);
    #1;
    check("R2", fb_out, 1'b1);
    check("R2", pad_out, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_200_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule